// File: doc/BRIEF.md
# Multichannel Reference Mixer and Snapshot Subsampler

This block sits between a multichannel array receiver and a space-time detector. Each input beat carries one complex sample from each of eight receive channels, plus one complex sample of the clean reference stream. The reference passes through a delay line that holds up to `LAG_MAX` past samples. Every channel sample is multiplied by the complex conjugate of the reference sample from `n` beats earlier, where `n` is the selected range lag. The block keeps every S-th mixed snapshot, counted from the first beat of a vector. Once M snapshots are stored, it streams them out as one space-time vector of N·M complex elements.

The block runs in two phases. In the fill phase `in_ready` is high and each handshake (`in_valid && in_ready`) takes one beat. In the drain phase `in_ready` is low, so no input is taken, and `out_valid` stays high until every element has been accepted with `out_ready`. While `out_valid` is high and `out_ready` is low, the element on `out_data` and the `out_last` flag are held unchanged. After the final element is accepted, the block returns to fill and pulses `vec_done`. The lag, step and length pins are sampled on the first accepted beat of each vector and held until that vector has drained.

Top module: `ref_mix_subsampler`

## Requirements
- R1: During and after reset, `in_ready`=1, `out_valid`=0, `out_last`=0 and `vec_done`=0. Reset clears the decimation and snapshot counters, so the next vector starts at k=0. Reset also zeroes the reference history, so any reference taken from before the reset reads as 0+0j.
- R2: Each mixed value equals x·conj(r): re = xr·rr + xi·ri and im = xi·rr − xr·ri. Both sums are formed at the full 49-bit width and bits 39..16 are kept (wrap-around, no rounding or saturation). Each sample part is 24-bit two's complement with 16 fractional bits. In `in_chan`, channel c has its real part at bits [48c+23:48c] and its imaginary part at [48c+47:48c+24]. `in_ref` and `out_data` place the real part in [23:0] and the imaginary part in [47:24].
- R3: The reference used for beat t is the one accepted at beat t−n, counting only accepted beats. n=0 uses the reference of the same beat. A lag above `LAG_MAX` (16) acts as 16.
- R4: Within a vector, beats k = 0, S, 2S, …, (M−1)S are kept, so (M−1)·S+1 beats are consumed per vector. A step of 0 acts as 1.
- R5: A length of 0 acts as 1, and a length above `MMAX` (8) acts as 8.
- R6: Output element e = m·N + c carries snapshot m, channel c (time-major, channel-minor). `out_last` is high only on element N·M−1.
- R7: Lag, step and length are sampled on the first accepted beat of a vector. Changes to those pins during the rest of that vector have no effect.
- R8: From the beat that completes a vector until its last element is accepted, `in_ready` is low and `in_valid` beats are ignored. In the cycle after the last element is accepted, `in_ready` is high and `out_valid` is low.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold.
- R10: `vec_done` is high for exactly one cycle, the cycle after the last element is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lag | input | 5 | Range lag n in beats |
| cfg_step | input | 4 | Decimation step S |
| cfg_len | input | 4 | Snapshots per vector M |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts an input beat |
| in_chan | input | 384 | Eight complex channel samples |
| in_ref | input | 48 | Complex reference sample |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Downstream accepts the element |
| out_data | output | 48 | Complex output element |
| out_last | output | 1 | Final element of the vector |
| vec_done | output | 1 | One-cycle pulse after a vector has drained |

## Verification
The mixing and stacking path is driven with several patterns:
- Small integer ramps make channel and snapshot misordering visible.
- Hashed full-range words expose errors in conjugate sign and in real/imaginary placement.
- Alternating full-scale extremes reach the widest product sums and check the wrap-around truncation point.
- Tiny raw values probe the bits that the 16-bit shift drops.

Lag, step and length are swept across zero, ordinary values and out-of-range values, so the clamps and the decimation spacing are each separated out. The back-pressure runs hold `out_ready` low while also offering junk input beats; a following vector with a nonzero lag would expose any shift of the reference history. A reset in the middle of a vector, followed by a lag-1 vector, shows whether the counters and the reference history were cleared.

// File: rtl/rms_pkg.sv
package rms_pkg;
  localparam int SMP_W    = 24;
  localparam int SMP_FRAC = 16;

  typedef struct packed {
    logic signed [SMP_W-1:0] im;
    logic signed [SMP_W-1:0] re;
  } cplx_t;

  typedef enum logic {PH_FILL = 1'b0, PH_DRAIN = 1'b1} phase_t;
endpackage

// File: rtl/rms_cmul.sv
// Product of a with the conjugate of b, full width kept until the final slice.
module rms_cmul
  import rms_pkg::*;
(
  input  cplx_t a,
  input  cplx_t b,
  output cplx_t p
);
  localparam int PW = 2 * SMP_W;
  localparam int SW = PW + 1;

  logic signed [PW-1:0] m_rr, m_ii, m_ir, m_ri;
  logic signed [SW-1:0] s_re, s_im;

  always_comb begin
    m_rr = PW'(a.re) * PW'(b.re);
    m_ii = PW'(a.im) * PW'(b.im);
    m_ir = PW'(a.im) * PW'(b.re);
    m_ri = PW'(a.re) * PW'(b.im);
    s_re = SW'(m_rr) + SW'(m_ii);
    s_im = SW'(m_ir) - SW'(m_ri);
    p.re = SMP_W'(s_re >>> SMP_FRAC);
    p.im = SMP_W'(s_im >>> SMP_FRAC);
  end
endmodule

// File: rtl/rms_refdelay.sv
// Reference history; tap 0 is the live sample, tap d is d accepted beats back.
module rms_refdelay
  import rms_pkg::*;
#(
  parameter int LAG_MAX = 16,
  parameter int LAG_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  cplx_t            ref_in,
  input  logic [LAG_W-1:0] lag,
  output cplx_t            tap
);
  localparam int HW = (LAG_MAX > 1) ? $clog2(LAG_MAX) : 1;

  cplx_t          hist [LAG_MAX];
  logic [HW-1:0]  sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAG_MAX; i++) hist[i] <= '0;
    end else if (shift_en) begin
      hist[0] <= ref_in;
      for (int i = 1; i < LAG_MAX; i++) hist[i] <= hist[i-1];
    end
  end

  always_comb begin
    sel = HW'(lag - 1'b1);
    if (lag == '0) tap = ref_in;
    else           tap = hist[sel];
  end
endmodule

// File: rtl/rms_snapbuf.sv
// Snapshot store: one row of NCH mixed samples per kept snapshot.
module rms_snapbuf
  import rms_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int MMAX   = 8,
  parameter int SNAP_W = 3,
  parameter int IDX_W  = 6
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [SNAP_W-1:0]   wr_snap,
  input  cplx_t [NCH-1:0]     din,
  input  logic [IDX_W-1:0]    rd_idx,
  output cplx_t               dout
);
  localparam int CH_W = $clog2(NCH);

  cplx_t             mem [MMAX][NCH];
  logic [SNAP_W-1:0] rd_snap;
  logic [CH_W-1:0]   rd_ch;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int c = 0; c < NCH; c++) mem[wr_snap][c] <= din[c];
    end
  end

  always_comb begin
    rd_snap = rd_idx[IDX_W-1:CH_W];
    rd_ch   = rd_idx[CH_W-1:0];
    dout    = mem[rd_snap][rd_ch];
  end
endmodule

// File: rtl/rms_ctrl.sv
// Phase sequencing, configuration capture, decimation and readout counters.
module rms_ctrl
  import rms_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int LAG_MAX = 16,
  parameter int MMAX    = 8,
  parameter int LAG_W   = 5,
  parameter int STEP_W  = 4,
  parameter int LEN_W   = 4,
  parameter int SNAP_W  = 3,
  parameter int IDX_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAG_W-1:0]  cfg_lag,
  input  logic [STEP_W-1:0] cfg_step,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_last,
  output logic              vec_done,
  output logic              shift_en,
  output logic              wr_en,
  output logic [SNAP_W-1:0] wr_snap,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [LAG_W-1:0]  lag_sel
);
  phase_t            phase;
  logic              armed, done_q;
  logic [LAG_W-1:0]  lat_lag, lag_pin;
  logic [STEP_W-1:0] lat_step, step_pin, step_eff, dec_cnt;
  logic [LEN_W-1:0]  lat_len, len_pin, len_eff, snap_cnt;
  logic [IDX_W-1:0]  rd_q, last_idx;
  logic              accept, keep, vec_full;

  always_comb begin
    lag_pin  = (cfg_lag > LAG_W'(LAG_MAX)) ? LAG_W'(LAG_MAX) : cfg_lag;
    step_pin = (cfg_step == '0) ? STEP_W'(1) : cfg_step;
    if (cfg_len == '0)                 len_pin = LEN_W'(1);
    else if (cfg_len > LEN_W'(MMAX))   len_pin = LEN_W'(MMAX);
    else                               len_pin = cfg_len;
    lag_sel  = armed ? lag_pin  : lat_lag;
    step_eff = armed ? step_pin : lat_step;
    len_eff  = armed ? len_pin  : lat_len;
    last_idx = IDX_W'(32'(lat_len) * NCH - 1);
  end

  assign in_ready  = (phase == PH_FILL);
  assign out_valid = (phase == PH_DRAIN);
  assign accept    = in_valid && in_ready;
  assign keep      = accept && (dec_cnt == '0);
  assign vec_full  = keep && (snap_cnt == len_eff - 1'b1);
  assign out_last  = out_valid && (rd_q == last_idx);
  assign vec_done  = done_q;
  assign shift_en  = accept;
  assign wr_en     = keep;
  assign wr_snap   = SNAP_W'(snap_cnt);
  assign rd_idx    = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_FILL;
      armed    <= 1'b1;
      done_q   <= 1'b0;
      lat_lag  <= '0;
      lat_step <= STEP_W'(1);
      lat_len  <= LEN_W'(1);
      dec_cnt  <= '0;
      snap_cnt <= '0;
      rd_q     <= '0;
    end else begin
      done_q <= out_last && out_ready;
      if (accept) begin
        if (armed) begin
          lat_lag  <= lag_pin;
          lat_step <= step_pin;
          lat_len  <= len_pin;
          armed    <= 1'b0;
        end
        if (vec_full) begin
          phase    <= PH_DRAIN;
          snap_cnt <= '0;
          dec_cnt  <= '0;
        end else begin
          if (keep) snap_cnt <= snap_cnt + 1'b1;
          dec_cnt <= (dec_cnt == step_eff - 1'b1) ? '0 : dec_cnt + 1'b1;
        end
      end
      if (out_valid && out_ready) begin
        if (out_last) begin
          phase <= PH_FILL;
          rd_q  <= '0;
          armed <= 1'b1;
        end else begin
          rd_q <= rd_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ref_mix_subsampler.sv
module ref_mix_subsampler
  import rms_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int LAG_MAX = 16,
  parameter int MMAX    = 8,
  parameter int LAG_W   = 5,
  parameter int STEP_W  = 4,
  parameter int LEN_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LAG_W-1:0]       cfg_lag,
  input  logic [STEP_W-1:0]      cfg_step,
  input  logic [LEN_W-1:0]       cfg_len,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NCH*2*SMP_W-1:0] in_chan,
  input  logic [2*SMP_W-1:0]     in_ref,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [2*SMP_W-1:0]     out_data,
  output logic                   out_last,
  output logic                   vec_done
);
  localparam int SNAP_W = (MMAX > 1) ? $clog2(MMAX) : 1;
  localparam int IDX_W  = $clog2(NCH * MMAX);

  cplx_t [NCH-1:0]   chan, mixed;
  cplx_t             ref_s, tap, dout;
  logic              shift_en, wr_en;
  logic [SNAP_W-1:0] wr_snap;
  logic [IDX_W-1:0]  rd_idx;
  logic [LAG_W-1:0]  lag_sel;

  assign chan     = in_chan;
  assign ref_s    = in_ref;
  assign out_data = dout;

  rms_ctrl #(
    .NCH(NCH), .LAG_MAX(LAG_MAX), .MMAX(MMAX), .LAG_W(LAG_W),
    .STEP_W(STEP_W), .LEN_W(LEN_W), .SNAP_W(SNAP_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_lag(cfg_lag), .cfg_step(cfg_step),
    .cfg_len(cfg_len), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .out_last(out_last),
    .vec_done(vec_done), .shift_en(shift_en), .wr_en(wr_en),
    .wr_snap(wr_snap), .rd_idx(rd_idx), .lag_sel(lag_sel)
  );

  rms_refdelay #(.LAG_MAX(LAG_MAX), .LAG_W(LAG_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ref_in(ref_s),
    .lag(lag_sel), .tap(tap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_mix
    rms_cmul u_mul (.a(chan[c]), .b(tap), .p(mixed[c]));
  end

  rms_snapbuf #(.NCH(NCH), .MMAX(MMAX), .SNAP_W(SNAP_W), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .wr_en(wr_en), .wr_snap(wr_snap), .din(mixed),
    .rd_idx(rd_idx), .dout(dout)
  );
endmodule

// File: rtl/rms_chk.sv
module rms_chk
  import rms_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_last,
  input logic [2*SMP_W-1:0] out_data,
  input logic               vec_done
);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> vec_done);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_done |=> !vec_done);

  // R8
  resume_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

  // R8
  drain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_ready && out_last)) |=> !in_ready);
endmodule

bind ref_mix_subsampler rms_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last), .out_data(out_data),
  .vec_done(vec_done)
);

// File: tb/ref_mix_subsampler_bench.sv
module ref_mix_subsampler_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [4:0]   cfg_lag = '0;
  logic [3:0]   cfg_step = 4'd1;
  logic [3:0]   cfg_len = 4'd1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [383:0] in_chan = '0;
  logic [47:0]  in_ref = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [47:0]  out_data;
  logic         out_last;
  logic         vec_done;

  int nchk = 0;
  int nfail = 0;
  int gidx = 0;
  int gbase = 0;

  logic signed [23:0] x_re [0:511][0:7];
  logic signed [23:0] x_im [0:511][0:7];
  logic signed [23:0] r_re [0:511];
  logic signed [23:0] r_im [0:511];

  // fields: lag, step, len, pattern, change-config-mid-vector, stall drain
  localparam logic [47:0] TBL [9] = '{
    {8'd0,  8'd1,  8'd8,  8'd0, 8'd0, 8'd0},
    {8'd3,  8'd2,  8'd4,  8'd1, 8'd0, 8'd1},
    {8'd16, 8'd3,  8'd8,  8'd2, 8'd0, 8'd0},
    {8'd5,  8'd1,  8'd1,  8'd1, 8'd0, 8'd0},
    {8'd25, 8'd0,  8'd3,  8'd3, 8'd0, 8'd0},
    {8'd2,  8'd4,  8'd5,  8'd1, 8'd1, 8'd0},
    {8'd7,  8'd5,  8'd12, 8'd0, 8'd0, 8'd1},
    {8'd1,  8'd15, 8'd2,  8'd2, 8'd0, 8'd0},
    {8'd4,  8'd2,  8'd0,  8'd3, 8'd0, 8'd0}
  };

  ref_mix_subsampler u_ref_mix_subsampler (
    .clk(clk), .rst_n(rst_n), .cfg_lag(cfg_lag), .cfg_step(cfg_step),
    .cfg_len(cfg_len), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_ref(in_ref), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .vec_done(vec_done)
  );

  always #10 clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string what, input logic [47:0] act, input logic [47:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic signed [23:0] smp(int pat, int g, int lane);
    int v;
    logic [31:0] h;
    case (pat)
      0: v = (((g * 7 + lane * 13) % 41) - 20) * 65536;
      1: begin
        h = (32'(g) * 32'h9E3779B1) ^ (32'(lane) * 32'h85EBCA6B);
        h = h ^ (h >> 15);
        v = int'(h);
      end
      2: v = ((g + lane) % 3 == 0) ? -8388608 : (((g + lane) % 3 == 1) ? 8388607 : -8388607);
      default: v = ((g * 5 + lane * 3) % 17) - 8;
    endcase
    return 24'(v);
  endfunction

  function automatic logic [47:0] expect_elem(int t, int c, int lag);
    longint xr, xi, rr, ri, pr, pi;
    xr = longint'(x_re[t][c]);
    xi = longint'(x_im[t][c]);
    if (t - lag < gbase) begin
      rr = 0;
      ri = 0;
    end else begin
      rr = longint'(r_re[t-lag]);
      ri = longint'(r_im[t-lag]);
    end
    pr = xr * rr + xi * ri;
    pi = xi * rr - xr * ri;
    return {24'(pi >>> 16), 24'(pr >>> 16)};
  endfunction

  task automatic drive_beat(int pat);
    for (int c = 0; c < 8; c++) begin
      x_re[gidx][c] = smp(pat, gidx, 2 * c);
      x_im[gidx][c] = smp(pat, gidx, 2 * c + 1);
      in_chan[c*48 +: 24]      = x_re[gidx][c];
      in_chan[c*48 + 24 +: 24] = x_im[gidx][c];
    end
    r_re[gidx] = smp(pat, gidx, 16);
    r_im[gidx] = smp(pat, gidx, 17);
    in_ref = {r_im[gidx], r_re[gidx]};
    in_valid = 1'b1;
  endtask

  task automatic run_vec(int lag, int step, int len, int pat, bit chg, bit stall, string tag);
    int le, se, me, beats, t0, nel;
    logic [47:0] hold, ex;
    le = (lag > 16) ? 16 : lag;
    se = (step == 0) ? 1 : step;
    me = (len == 0) ? 1 : ((len > 8) ? 8 : len);
    beats = (me - 1) * se + 1;
    nel = me * 8;
    @(negedge clk);
    cfg_lag = 5'(lag);
    cfg_step = 4'(step);
    cfg_len = 4'(len);
    t0 = gidx;
    for (int b = 0; b < beats; b++) begin
      if (b > 0) @(negedge clk);
      if (b > 0 && chg) begin
        cfg_lag = 5'(lag) ^ 5'd5;
        cfg_step = 4'(step) ^ 4'd3;
        cfg_len = 4'(len) ^ 4'd6;
      end
      chk(in_ready == 1'b1, "R8 in_ready during fill", 48'(in_ready), 48'd1);
      drive_beat(pat);
      @(posedge clk);
      gidx++;
    end
    @(negedge clk);
    if (stall) begin
      in_chan = '1;
      in_ref = 48'h123456_654321;
      in_valid = 1'b1;
    end else begin
      in_valid = 1'b0;
    end
    chk(!in_ready && out_valid, "R4/R8 drain after (M-1)S+1 beats", {in_ready, out_valid}, 48'b01);
    for (int e = 0; e < nel; e++) begin
      if (!(stall && (e % 3 == 1))) @(negedge clk);
      if (stall && (e % 3 == 1)) begin
        @(negedge clk);
        out_ready = 1'b0;
        hold = out_data;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid && (out_data == hold) && !in_ready, "R9 hold under stall", out_data, hold);
      end
      out_ready = 1'b1;
      ex = expect_elem(t0 + (e / 8) * se, e % 8, le);
      chk(out_valid && (out_data == ex), tag, out_data, ex);
      chk(out_last == (e == nel - 1), "R6/R5 last flag position", 48'(out_last), 48'(e == nel - 1));
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b0;
    chk(vec_done == 1'b1, "R10 done pulse", 48'(vec_done), 48'd1);
    chk(in_ready && !out_valid, "R8 fill resumes", {in_ready, out_valid}, 48'b10);
    @(negedge clk);
    chk(vec_done == 1'b0, "R10 done single cycle", 48'(vec_done), 48'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid && !out_last && !vec_done, "R1 reset state",
        {in_ready, out_valid, out_last, vec_done}, 48'b1000);
    rst_n = 1'b1;
    for (int i = 0; i < 9; i++) begin
      run_vec(int'(TBL[i][47:40]), int'(TBL[i][39:32]), int'(TBL[i][31:24]),
              int'(TBL[i][23:16]), TBL[i][15:8] != 0, TBL[i][7:0] != 0,
              (TBL[i][15:8] != 0) ? "R7 data with config changed mid-vector"
                                  : "R2/R3/R4 mixed data");
    end
    // reset in the middle of a vector
    @(negedge clk);
    cfg_lag = 5'd1;
    cfg_step = 4'd2;
    cfg_len = 4'd4;
    for (int b = 0; b < 3; b++) begin
      if (b > 0) @(negedge clk);
      drive_beat(1);
      @(posedge clk);
      gidx++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    gbase = gidx;
    @(negedge clk);
    chk(in_ready && !out_valid && !out_last && !vec_done, "R1 state after mid-vector reset",
        {in_ready, out_valid, out_last, vec_done}, 48'b1000);
    rst_n = 1'b1;
    run_vec(1, 2, 4, 0, 1'b0, 1'b0, "R1 cleared counters and history");
    run_vec(0, 3, 2, 2, 1'b0, 1'b1, "R2/R3 data after reset");
    summary();
    $finish;
  end
endmodule